// File: doc/BRIEF.md
# Fixed-Peripheral DMA Channel

This block is one DMA channel that copies bytes between a memory location and a single peripheral register. The peripheral register sits in the top 256 bytes of a 24-bit address space. Software programs four registers through a small write port:

- an 8-bit peripheral pointer,
- a 24-bit memory pointer,
- a 16-bit transfer count,
- a control word that holds the enable, the step direction, the idle-mode switch and the activation-source code.

Each accepted trigger runs one bus read followed by one bus write. After each transfer the channel lowers the count by one. When the count runs out, the channel switches itself off and raises an end flag and an interrupt pulse.

The peripheral pointer never moves. The activation-source code, not a separate direction bit, decides whether that pointer is read from or written to. The memory pointer steps by one in either direction after each transfer, or it stays fixed in idle mode. A trigger that arrives during a transfer is held and served afterwards. A count written during a transfer is held until that transfer finishes.

Top module: `sadma_chan`

## Requirements
- R1: The peripheral-side bus address is 0xFFFF in bits 23:8 with the 8-bit peripheral pointer (register select 0) in bits 7:0. The pointer reads back unchanged and never steps across transfers.
- R2: With source code (control bits 5:3) 0 or 1, the peripheral address is the read side and memory is the write side. Any other code reverses the roles.
- R3: Each accepted trigger gives exactly one read cycle (bus_wr=0), then one write cycle (bus_wr=1) that carries the byte just read. Each cycle holds bus_req, bus_wr and bus_addr steady until bus_ack.
- R4: The transfer count (register select 2) drops by one after each completed transfer.
- R5: In I/O mode (control bit 2 = 0), the memory pointer (register select 1) steps +1 after each transfer when control bit 1 = 0, and −1 when it is 1. In idle mode (bit 2 = 1) it stays fixed.
- R6: When a transfer brings the count to zero, the channel clears the enable bit (control bit 0), sets the sticky end flag (control read bit 6) and drives irq high for exactly one cycle.
- R7: A trigger while the channel is disabled starts no bus activity and changes no register.
- R8: A trigger that arrives during a transfer is held and produces one more transfer after the current one.
- R9: A count written during a transfer does not disturb that transfer. At its end the written value replaces the count instead of the decremented one.
- R10: After reset, bus_req and irq are low and the memory pointer, count and control word read as zero.
- R11: Any write to the control word clears the end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 peripheral pointer, 1 memory pointer, 2 count, 3 control |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Read data of the selected register |
| trig | input | 1 | Activation request |
| bus_req | output | 1 | Bus cycle request |
| bus_wr | output | 1 | Cycle is a write when high |
| bus_addr | output | 24 | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled with bus_ack in a read cycle |
| bus_ack | input | 1 | Cycle completion |
| irq | output | 1 | End-of-transfer pulse |

## Verification
A wrong source code decode or a corrupted peripheral pointer shows on bus_addr in the first cycle of the next transfer, because read and write addresses then swap or lose their 0xFFFF prefix. A count or memory pointer that steps wrongly can be seen on the register read port as soon as the write cycle is acknowledged. A count that is wrong in a quiet way shows up later: irq and the end flag fire one transfer early or late. A lost pending trigger or a count load applied too early changes how many bus cycles the bench sees before the channel stops.

// File: rtl/sadma_chan.sv
module sadma_chan #(
  parameter int AW = 24,
  parameter int PW = 8,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          trig,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          irq
);
  localparam int HW = AW - PW;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [PW-1:0] per_q;
  logic [AW-1:0] mem_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_ld, en, dir, idle_m, done, pend;
  logic [2:0]    src;
  logic [DW-1:0] dat_q;

  wire          per_src = (src == 3'd0) || (src == 3'd1);
  wire [AW-1:0] per_full = {{HW{1'b1}}, per_q};
  wire          fin = (st == S_WR) && bus_ack;
  wire [CW-1:0] cnt_dec = cnt_q - 1'b1;
  wire [CW-1:0] cnt_after = cnt_ld ? cnt_nx : cnt_dec;
  wire          last = fin && (cnt_after == '0);
  wire          go = (st == S_IDLE) && en && (trig || pend);
  wire          wsel0 = reg_we && (reg_addr == 2'd0);
  wire          wsel1 = reg_we && (reg_addr == 2'd1);
  wire          wsel2 = reg_we && (reg_addr == 2'd2);
  wire          wsel3 = reg_we && (reg_addr == 2'd3);

  assign bus_req   = (st != S_IDLE);
  assign bus_wr    = (st == S_WR);
  assign bus_addr  = ((st == S_RD) == per_src) ? per_full : mem_q;
  assign bus_wdata = dat_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{HW{1'b0}}, per_q};
      2'd1:    reg_rdata = mem_q;
      2'd2:    reg_rdata = {{(AW-CW){1'b0}}, cnt_q};
      default: reg_rdata = {{(AW-7){1'b0}}, done, src, idle_m, dir, en};
    endcase
  end

  always_ff @(posedge clk) begin
    if (wsel0) per_q <= reg_wdata[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mem_q <= '0;
      cnt_q <= '0;
      cnt_nx <= '0;
      cnt_ld <= 1'b0;
      en <= 1'b0;
      dir <= 1'b0;
      idle_m <= 1'b0;
      src <= '0;
      done <= 1'b0;
      pend <= 1'b0;
      dat_q <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (trig && en && st != S_IDLE) pend <= 1'b1;
      case (st)
        S_IDLE: if (go) begin
          st <= S_RD;
          pend <= pend && trig;
        end
        S_RD: if (bus_ack) begin
          dat_q <= bus_rdata;
          st <= S_WR;
        end
        S_WR: if (bus_ack) begin
          st <= S_IDLE;
          cnt_q <= cnt_after;
          cnt_ld <= 1'b0;
          if (!idle_m) mem_q <= dir ? mem_q - 1'b1 : mem_q + 1'b1;
          if (last) begin
            en <= 1'b0;
            done <= 1'b1;
            irq <= 1'b1;
            pend <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (wsel1) mem_q <= reg_wdata;
      if (wsel2) begin
        if (st == S_IDLE || fin) begin
          cnt_q <= reg_wdata[CW-1:0];
          cnt_ld <= 1'b0;
        end else begin
          cnt_nx <= reg_wdata[CW-1:0];
          cnt_ld <= 1'b1;
        end
      end
      if (wsel3) begin
        en <= reg_wdata[0];
        dir <= reg_wdata[1];
        idle_m <= reg_wdata[2];
        src <= reg_wdata[5:3];
        done <= 1'b0;
      end
    end
  end
endmodule

module sadma_chan_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_wr,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic          irq,
  input logic          en
);
  // R3
  start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_wr);
  // R3
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_wr) && $stable(bus_addr)));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6
  irq_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !en);
  // R7
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_req) |=> !bus_req);
endmodule

bind sadma_chan sadma_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_ack(bus_ack), .bus_addr(bus_addr), .irq(irq), .en(en)
);

// File: tb/sadma_chan_tb.sv
`timescale 1ns/1ps
module sadma_chan_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, reg_we, trig, bus_req, bus_wr, bus_ack, irq;
  logic [1:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata, bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  sadma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
  );

  logic [32:0] exp_q[$];
  int total = 0, bad = 0, irq_seen = 0;
  bit finished = 0;

  task automatic chk(string req, logic [23:0] act, logic [23:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic expect_xfer(logic [23:0] s, logic [23:0] d);
    exp_q.push_back({1'b0, s, 8'h00});
    exp_q.push_back({1'b1, d, s[7:0] ^ 8'h5A});
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #1; end while (exp_q.size() != 0 || bus_req);
    repeat (3) @(negedge clk);
  endtask

  // monitor and bus responder
  initial begin
    bus_ack = 1'b0; bus_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (irq) irq_seen++;
      if (bus_req && !bus_ack) begin
        logic [32:0] got;
        if (!bus_wr) bus_rdata = bus_addr[7:0] ^ 8'h5A;
        got = {bus_wr, bus_addr, bus_wr ? bus_wdata : 8'h00};
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R3/R7 unexpected bus cycle act=%h exp=none", got);
        end else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          if (got !== e) begin
            bad++;
            $display("FAIL R1/R2/R3 bus cycle act=%h exp=%h", got, e);
          end
        end
        bus_ack = 1'b1;
      end else bus_ack = 1'b0;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; trig = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 bus_req", {23'd0, bus_req}, 24'd0);
    chk("R10 irq", {23'd0, irq}, 24'd0);
    rd_reg(2'd1, v); chk("R10 mem", v, 24'd0);
    rd_reg(2'd2, v); chk("R10 count", v, 24'd0);
    rd_reg(2'd3, v); chk("R10 ctrl", v, 24'd0);

    // R2 source code 0: peripheral read, memory write, step up
    wr_reg(2'd0, 24'h000034);
    wr_reg(2'd1, 24'h001000);
    wr_reg(2'd2, 24'd3);
    wr_reg(2'd3, 24'h000001);
    expect_xfer(24'hFFFF34, 24'h001000);
    pulse_trig(); wait_idle();
    rd_reg(2'd2, v); chk("R4 count after one", v, 24'd2);
    rd_reg(2'd1, v); chk("R5 mem step up", v, 24'h001001);
    rd_reg(2'd0, v); chk("R1 peripheral pointer fixed", v, 24'h000034);

    // R2 source code 4: peripheral written, step down
    wr_reg(2'd3, 24'h000023);
    expect_xfer(24'h001001, 24'hFFFF34);
    pulse_trig(); wait_idle();
    rd_reg(2'd1, v); chk("R5 mem step down", v, 24'h001000);
    rd_reg(2'd2, v); chk("R4 count after two", v, 24'd1);

    // R6 end of count with source code 1
    wr_reg(2'd3, 24'h00000B);
    expect_xfer(24'hFFFF34, 24'h001000);
    pulse_trig(); wait_idle();
    rd_reg(2'd2, v); chk("R6 count zero", v, 24'd0);
    rd_reg(2'd3, v); chk("R6 ctrl en clear done set", v, 24'h00004A);
    chk("R6 irq pulses", irq_seen, 24'd1);

    // R7 triggers ignored while disabled
    pulse_trig(); pulse_trig();
    repeat (10) @(negedge clk);
    chk("R7 no bus activity", {23'd0, bus_req}, 24'd0);
    rd_reg(2'd2, v); chk("R7 count unchanged", v, 24'd0);
    rd_reg(2'd1, v); chk("R7 mem unchanged", v, 24'h000FFF);

    // R11 control write clears end flag
    wr_reg(2'd3, 24'h000008);
    rd_reg(2'd3, v); chk("R11 done cleared", v, 24'h000008);

    // R8 pending trigger, R5 idle mode
    wr_reg(2'd1, 24'h002000);
    wr_reg(2'd2, 24'd3);
    wr_reg(2'd3, 24'h000015);
    expect_xfer(24'h002000, 24'hFFFF34);
    expect_xfer(24'h002000, 24'hFFFF34);
    pulse_trig();
    do @(negedge clk); while (!bus_req);
    pulse_trig();
    wait_idle();
    rd_reg(2'd2, v); chk("R8 two transfers ran", v, 24'd1);
    rd_reg(2'd1, v); chk("R5 idle mode fixed", v, 24'h002000);

    // R9 count written during a transfer
    wr_reg(2'd2, 24'd5);
    expect_xfer(24'h002000, 24'hFFFF34);
    pulse_trig();
    do @(negedge clk); while (!bus_req);
    wr_reg(2'd2, 24'd2);
    wait_idle();
    rd_reg(2'd2, v); chk("R9 count load at boundary", v, 24'd2);
    expect_xfer(24'h002000, 24'hFFFF34);
    pulse_trig(); wait_idle();
    expect_xfer(24'h002000, 24'hFFFF34);
    pulse_trig(); wait_idle();
    rd_reg(2'd2, v); chk("R9 count ends", v, 24'd0);
    rd_reg(2'd3, v); chk("R6 ctrl after second end", v, 24'h000054);
    chk("R6 second irq", irq_seen, 24'd2);
    chk("R3 queue drained", exp_q.size(), 24'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule